// File: doc/BRIEF.md
# Two-Policy Priority Interrupt Controller

This controller sits between four peripheral request lines and the single interrupt input of a processor. It latches each request as pending and raises `irq_o` when a pending source may be serviced. The processor answers with a one-cycle `ack_i` pulse. In that same cycle the controller presents the chosen source on `src_id_o` and marks it in service. When the handler finishes, the processor pulses `eos_i`, which retires one in-service level.

Source IDs are fixed:

| ID | Source | Priority |
|----|--------|----------|
| 0 | program exception (for example arithmetic overflow or divide by zero) | lowest |
| 1 | internal timer | |
| 2 | I/O controller | |
| 3 | hardware failure (for example memory parity) | highest |

A run-time input `nest_i` selects how sources are chosen:

- **Sequential (`nest_i` = 0):** while anything is in service, the interrupt line stays quiet. Requests keep collecting as pending and are released one at a time, in the order they arrived.
- **Nested (`nest_i` = 1):** a source that outranks every level currently in service interrupts immediately. Retiring a level returns service to the level that was interrupted.

Top module: `irqc_top`

## Requirements
- R1: While reset is applied and after it is released, `irq_o` is low and `isr_o` is all zero. No request is pending.
- R2: A request pulse of one or more cycles on `req_i[k]` marks source k pending. With nothing in service, `irq_o` is high from the next cycle, and `src_id_o` equals k (0 program, 1 timer, 2 I/O, 3 hardware failure).
- R3: An `ack_i` pulse while `irq_o` is high takes the source shown on `src_id_o` in that cycle. That source's bit is set in `isr_o` (bit index = ID) and its pending status is removed.
- R4: In sequential mode, `irq_o` stays low while `isr_o` is non-zero. Requests arriving meanwhile stay pending.
- R5: In sequential mode, pending sources are offered in arrival order, regardless of priority. Sources that arrive in the same cycle are ordered highest ID first.
- R6: A request for a source that is already pending does not add a second service. The source is offered exactly once.
- R7: In nested mode, a pending source whose ID is above the highest set bit of `isr_o` raises `irq_o` even while lower levels are in service.
- R8: In nested mode, a pending source whose ID is equal to or below the highest in-service bit does not raise `irq_o`.
- R9: An `eos_i` pulse clears only the highest set bit of `isr_o`, so nested levels unwind last-in, first-out.
- R10: In nested mode, with several sources pending and eligible, the highest ID is offered, whatever the arrival order.
- R11: An `ack_i` pulse while `irq_o` is low changes neither `isr_o` nor the pending set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| nest_i | input | 1 | Policy select: 0 sequential, 1 nested |
| req_i | input | NSRC | Request lines, bit index = source ID |
| ack_i | input | 1 | One-cycle acknowledge from the processor |
| eos_i | input | 1 | One-cycle end-of-service strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| src_id_o | output | $clog2(NSRC) | ID of the offered source, valid while `irq_o` is high |
| isr_o | output | NSRC | In-service mask, bit index = source ID |

## Verification
The bench builds the controller with its default of four sources. In that configuration each source has its own ID, and the arrival queue has exactly as many slots as there are sources. This lets the bench fill the queue completely: all four sources are held pending behind a busy sequential service, and it checks that they come out in arrival order. It also stacks three nested levels, so that the last-in, first-out unwind and the higher-ID choice among waiting sources can both be observed.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic {
    POL_SEQ  = 1'b0,
    POL_NEST = 1'b1
  } policy_e;

  // index of the highest set bit of a vector (0 when empty)
  function automatic int unsigned msb_idx(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/irqc_pendq.sv
module irqc_pendq #(
  parameter int NSRC = 4,
  parameter int IDW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic            take,
  input  logic [IDW-1:0]  take_id,
  output logic [NSRC-1:0] pend,
  output logic [IDW-1:0]  head_id,
  output logic            q_nonempty
);
  localparam int CW = $clog2(NSRC + 1);

  logic [NSRC-1:0] pend_q, pend_d, take_mask, arrive;
  logic [IDW-1:0]  slot_q [NSRC];
  logic [IDW-1:0]  slot_d [NSRC];
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            upd;

  always_comb begin
    take_mask = '0;
    if (take) take_mask[take_id] = 1'b1;
    pend_d = (pend_q & ~take_mask) | req;
    arrive = req & ~(pend_q & ~take_mask);
  end

  // compaction of the taken entry, then append of new arrivals
  always_comb begin
    int pos;
    int wr;
    pos = NSRC;
    for (int i = 0; i < NSRC; i++) begin
      if (take && (i < int'(cnt_q)) && (slot_q[i] == take_id) && (pos == NSRC)) pos = i;
    end
    for (int i = 0; i < NSRC; i++) begin
      if ((i >= pos) && (i + 1 < NSRC)) slot_d[i] = slot_q[i+1];
      else                              slot_d[i] = slot_q[i];
    end
    wr = int'(cnt_q) - ((pos < NSRC) ? 1 : 0);
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (arrive[k] && (wr < NSRC)) begin
        slot_d[wr] = IDW'(k);
        wr = wr + 1;
      end
    end
    cnt_d = CW'(wr);
  end

  assign upd = take | (|req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < NSRC; i++) slot_q[i] <= '0;
    end else if (upd) begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      for (int i = 0; i < NSRC; i++) slot_q[i] <= slot_d[i];
    end
  end

  assign pend       = pend_q;
  assign head_id    = slot_q[0];
  assign q_nonempty = (cnt_q != '0);

  AST_QUEUE_TRACKS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) == $countones(pend_q)); // R6
  AST_HEAD_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> pend_q[slot_q[0]]); // R5

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int IDW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  policy_e         pol,
  input  logic [NSRC-1:0] pend,
  input  logic [IDW-1:0]  head_id,
  input  logic            q_nonempty,
  input  logic [NSRC-1:0] isr,
  output logic            irq,
  output logic [IDW-1:0]  sel_id
);
  logic [IDW-1:0] top_pend, top_isr;

  always_comb begin
    top_pend = IDW'(msb_idx(32'(pend)));
    top_isr  = IDW'(msb_idx(32'(isr)));
    if (pol == POL_SEQ) begin
      irq    = (isr == '0) && q_nonempty;
      sel_id = head_id;
    end else begin
      irq    = (pend != '0) && ((isr == '0) || (top_pend > top_isr));
      sel_id = top_pend;
    end
  end

endmodule

// File: rtl/irqc_svc.sv
module irqc_svc
  import irqc_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int IDW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack_ok,
  input  logic [IDW-1:0]  ack_id,
  input  logic            eos,
  output logic [NSRC-1:0] isr
);
  logic [NSRC-1:0] isr_q, isr_d, clr, set;
  logic            en;

  always_comb begin
    clr = '0;
    set = '0;
    if (eos && (isr_q != '0)) clr[msb_idx(32'(isr_q))] = 1'b1;
    if (ack_ok) set[ack_id] = 1'b1;
    isr_d = (isr_q & ~clr) | set;
  end

  assign en = ack_ok | eos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  isr_q <= '0;
    else if (en) isr_q <= isr_d;
  end

  assign isr = isr_q;

  AST_EOS_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !ack_ok && (isr_q != '0)) |=> ($countones(isr_q) + 1 == $countones($past(isr_q)))); // R9
  AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |=> isr_q[$past(ack_id)]); // R3

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NSRC = 4,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nest_i,
  input  logic [NSRC-1:0] req_i,
  input  logic            ack_i,
  input  logic            eos_i,
  output logic            irq_o,
  output logic [IDW-1:0]  src_id_o,
  output logic [NSRC-1:0] isr_o
);
  logic [1:0]      rs_q;
  logic            rst_s_n;
  logic [NSRC-1:0] pend;
  logic [IDW-1:0]  head_id;
  logic            q_nonempty;
  logic            ack_ok;
  policy_e         pol;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  assign pol    = policy_e'(nest_i);
  assign ack_ok = ack_i & irq_o;

  irqc_pendq #(.NSRC(NSRC), .IDW(IDW)) u_pendq (
    .clk(clk), .rst_n(rst_s_n), .req(req_i),
    .take(ack_ok), .take_id(src_id_o),
    .pend(pend), .head_id(head_id), .q_nonempty(q_nonempty)
  );

  irqc_arb #(.NSRC(NSRC), .IDW(IDW)) u_arb (
    .pol(pol), .pend(pend), .head_id(head_id), .q_nonempty(q_nonempty),
    .isr(isr_o), .irq(irq_o), .sel_id(src_id_o)
  );

  irqc_svc #(.NSRC(NSRC), .IDW(IDW)) u_svc (
    .clk(clk), .rst_n(rst_s_n), .ack_ok(ack_ok), .ack_id(src_id_o),
    .eos(eos_i), .isr(isr_o)
  );

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
    !rst_s_n |-> (!irq_o && (isr_o == '0))); // R1
  AST_IRQ_NAMES_PENDING: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_o |-> pend[src_id_o]); // R2
  AST_SEQ_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!nest_i && (isr_o != '0)) |-> !irq_o); // R4
  AST_NEST_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (nest_i && irq_o) |-> !isr_o[src_id_o]); // R8
  AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ack_i && !irq_o && !eos_i) |=> $stable(isr_o)); // R11

endmodule

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
  localparam int CLK_P = 10;
  localparam int NSRC  = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            nest_i;
  logic [NSRC-1:0] req_i;
  logic            ack_i, eos_i;
  logic            irq_o;
  logic [1:0]      src_id_o;
  logic [NSRC-1:0] isr_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] expq [$];

  always #(CLK_P/2) clk = ~clk;

  irqc_top #(.NSRC(NSRC)) u0 (
    .clk(clk), .rst_n(rst_n), .nest_i(nest_i), .req_i(req_i),
    .ack_i(ack_i), .eos_i(eos_i), .irq_o(irq_o), .src_id_o(src_id_o), .isr_o(isr_o)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_req(input logic [NSRC-1:0] v);
    req_i = v; tick(); req_i = '0;
  endtask

  task automatic pulse_eos();
    eos_i = 1'b1; tick(); eos_i = 1'b0;
  endtask

  // driver: expect an offer of id, push it to the scoreboard, acknowledge
  task automatic serve(input string tag, input logic [1:0] id);
    chk({tag, " irq before ack"}, int'(irq_o), 1);
    expq.push_back(id);
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    chk({tag, " isr bit after ack (R3)"}, int'(isr_o[id]), 1);
  endtask

  // monitor: compares the presented id on every accepted acknowledge
  always @(negedge clk) begin
    if (rst_n && ack_i && irq_o) begin
      n_chk++;
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL R5/R10 unexpected ack actual=%0d expected=none", src_id_o);
      end else begin
        logic [1:0] e;
        e = expq.pop_front();
        if (src_id_o != e) begin
          n_bad++;
          $display("FAIL R5/R10 offered id actual=%0d expected=%0d", src_id_o, e);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; nest_i = 1'b0; req_i = '0; ack_i = 1'b0; eos_i = 1'b0;
    tick(); tick();
    chk("R1 irq in reset", int'(irq_o), 0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk("R1 irq after reset", int'(irq_o), 0);
    chk("R1 isr after reset", int'(isr_o), 0);

    // sequential policy
    pulse_req(4'b0001);
    chk("R2 irq raised", int'(irq_o), 1);
    chk("R2 id program", int'(src_id_o), 0);
    serve("R3", 2'd0);
    chk("R4 irq held", int'(irq_o), 0);
    pulse_req(4'b0010);
    pulse_req(4'b1000);
    pulse_req(4'b1000);  // R6 repeat while pending
    pulse_req(4'b0101);  // R5 simultaneous: 2 before 0
    chk("R4 irq held with four pending", int'(irq_o), 0);
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    chk("R11 stray ack isr", int'(isr_o), 1);
    chk("R11 stray ack irq", int'(irq_o), 0);
    pulse_eos();
    chk("R9 isr cleared", int'(isr_o), 0);
    chk("R5 first arrival id", int'(src_id_o), 1);
    serve("R5", 2'd1);
    pulse_eos();
    serve("R5", 2'd3);
    pulse_eos();
    serve("R5", 2'd2);
    pulse_eos();
    serve("R5", 2'd0);
    pulse_eos();
    chk("R6 single hw service irq", int'(irq_o), 0);
    chk("R6 isr empty", int'(isr_o), 0);

    // nested policy
    nest_i = 1'b1;
    tick();
    pulse_req(4'b0010);
    serve("R7", 2'd1);
    pulse_req(4'b0001);
    chk("R8 lower waits", int'(irq_o), 0);
    pulse_req(4'b0010);
    chk("R8 equal waits", int'(irq_o), 0);
    pulse_req(4'b0100);
    chk("R7 preempt irq", int'(irq_o), 1);
    chk("R7 preempt id", int'(src_id_o), 2);
    serve("R7", 2'd2);
    pulse_req(4'b1000);
    chk("R7 second preempt id", int'(src_id_o), 3);
    serve("R7", 2'd3);
    chk("R7 three levels", int'(isr_o), 14);
    pulse_eos();
    chk("R9 unwind to io", int'(isr_o), 6);
    chk("R8 still quiet", int'(irq_o), 0);
    pulse_eos();
    chk("R9 unwind to timer", int'(isr_o), 2);
    chk("R8 equal still waits", int'(irq_o), 0);
    pulse_eos();
    chk("R9 all retired", int'(isr_o), 0);
    chk("R10 highest pending id", int'(src_id_o), 1);
    serve("R10", 2'd1);
    pulse_eos();
    serve("R10", 2'd0);
    pulse_eos();
    chk("R2 idle irq", int'(irq_o), 0);
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    chk("R11 idle ack isr", int'(isr_o), 0);
    pulse_req(4'b0001);
    chk("R11 pending kept id", int'(src_id_o), 0);
    serve("R11", 2'd0);
    pulse_eos();
    tick();
    chk("R3 scoreboard drained", expq.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule